// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out atomic memory operations for a 64-bit core. The pipeline hands it one instruction word together with the values of the two source registers and the current atomic-extension enable bit. The block decodes the instruction and checks that it is legal. It then runs a locked two-step exchange on a simple request/response memory port. The first step reads the target location. The second step writes back the combination of the old value and the second operand. When the write has been acknowledged, the block returns the old value for the destination register.

Four combining operations are supported: add, bitwise and, signed maximum and unsigned maximum. Each comes in a 32-bit word form and a 64-bit doubleword form. A word access touches only one aligned half of the 64-bit data bus. Address bit 2 selects that half, and the byte enables mark it. The old word comes back sign-extended. An instruction that cannot be run, or that arrives while the enable bit is low, finishes as illegal and makes no memory access. The ordering hint bits are not acted on; they are copied onto the memory request.

Top module: `amo_rmw_unit`

## Requirements
- R1: An instruction is legal only when all of these hold: bits 6:0 are 0101111; bits 14:12 are 010 (word) or 011 (doubleword, only when the `DWORD_EN` parameter is 1); bits 31:27 are one of 00000 (add), 01100 (and), 10100 (signed max) or 11100 (unsigned max). The destination index is taken from bits 11:7 and shown on `rd_idx_o` while `done_o` is high.
- R2: A legal instruction makes exactly one read request and then exactly one write request, both to the address held in rs1. `mem_lock_o` stays high on every request cycle and through the whole read-to-write span. No idle cycle separates the read phase from the write phase.
- R3: Add stores old plus operand, wrapping modulo the access width. `rd_val_o` returns the old value.
- R4: And stores the bitwise AND of the old value and the operand.
- R5: Signed max compares both values as two's-complement integers and stores the larger one. When the two are equal, that value is stored.
- R6: Unsigned max compares both values as unsigned integers and stores the larger one.
- R7: A word form uses only bits 31:0 of rs2. It operates on the 32-bit half chosen by address bit 2: 0 selects bits 31:0 with `mem_be_o` = 0x0F, and 1 selects bits 63:32 with `mem_be_o` = 0xF0. The other four bytes are left unchanged. `rd_val_o` is the old word sign-extended to 64 bits.
- R8: A doubleword form uses all 64 bits and requests with `mem_be_o` = 0xFF.
- R9: When `a_en_i` is low, an otherwise legal instruction ends with `illegal_o` high, `rd_val_o` zero and no memory request.
- R10: An instruction that fails R1 ends with `illegal_o` high, `rd_val_o` zero and no memory request.
- R11: Instruction bit 26 (acquire) drives `mem_aq_o` and bit 25 (release) drives `mem_rl_o` on every request cycle of that instruction.
- R12: `ready_o` is high only when the unit is idle. A `start_i` pulse that arrives while the unit is busy is ignored. `done_o` is a single-cycle pulse. For a legal instruction it comes one cycle after the write response; for an illegal one it comes one cycle after acceptance.
- R13: After reset the unit is idle: `ready_o` is high, and `mem_req_o`, `mem_lock_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Present an instruction; accepted only while ready_o is high |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | 64 | Address operand |
| rs2_val_i | input | 64 | Combining operand |
| a_en_i | input | 1 | Atomic extension currently enabled |
| ready_o | output | 1 | Unit idle and able to accept |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Completed instruction raised illegal instruction (valid with done_o) |
| rd_idx_o | output | 5 | Destination register index (valid with done_o) |
| rd_val_o | output | 64 | Value for the destination register (valid with done_o) |
| mem_req_o | output | 1 | Memory request, held until mem_rsp_i |
| mem_we_o | output | 1 | Request is a write |
| mem_lock_o | output | 1 | Location locked for the read-write pair |
| mem_aq_o | output | 1 | Acquire hint copied from the instruction |
| mem_rl_o | output | 1 | Release hint copied from the instruction |
| mem_addr_o | output | 64 | Request address |
| mem_be_o | output | 8 | Byte enables |
| mem_wdata_o | output | 64 | Write data |
| mem_rsp_i | input | 1 | Response; completes the current request |
| mem_rdata_i | input | 64 | Read data, valid with mem_rsp_i on a read |

## Verification
The in-RTL properties check the following on every cycle:
- the lock is held on each request;
- the write reuses the read address and follows the read without a gap;
- the byte-enable pattern matches the access width;
- write data stays steady while a write is held;
- done is a one-cycle pulse;
- a rejected instruction never reaches the memory port.

The arithmetic can be shown only by the bench's scenarios. That covers the stored result and the returned old value for each operation, signed and unsigned compare on values whose sign bits differ, wrap-around on add, sign extension from the upper and lower halves, and preservation of the untouched half. The same holds for ignoring a start while busy.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int XLEN = 64;
  localparam int NBYTES = XLEN / 8;

  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
  localparam logic [2:0] WIDTH_WORD = 3'b010;
  localparam logic [2:0] WIDTH_DWORD = 3'b011;

  localparam logic [4:0] SEL_ADD  = 5'b00000;
  localparam logic [4:0] SEL_AND  = 5'b01100;
  localparam logic [4:0] SEL_MAX  = 5'b10100;
  localparam logic [4:0] SEL_MAXU = 5'b11100;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_AND  = 2'd1,
    OP_MAX  = 2'd2,
    OP_MAXU = 2'd3
  } amo_op_e;

  typedef struct packed {
    logic       legal;
    amo_op_e    op;
    logic       dword;
    logic       aq;
    logic       rl;
    logic [4:0] rd;
  } amo_dec_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } amo_state_e;

  // 64-bit combine of old memory value a with operand b
  function automatic logic [63:0] combine64(amo_op_e op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    unique case (op)
      OP_ADD:  r = a + b;
      OP_AND:  r = a & b;
      OP_MAX:  r = ($signed(a) >= $signed(b)) ? a : b;
      default: r = (a >= b) ? a : b;
    endcase
    return r;
  endfunction

  // 32-bit combine of old memory word a with operand word b
  function automatic logic [31:0] combine32(amo_op_e op, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    unique case (op)
      OP_ADD:  r = a + b;
      OP_AND:  r = a & b;
      OP_MAX:  r = ($signed(a) >= $signed(b)) ? a : b;
      default: r = (a >= b) ? a : b;
    endcase
    return r;
  endfunction

  function automatic logic [63:0] sext32(logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter bit DWORD_EN = 1'b1
) (
  input  logic [31:0] insn_i,
  input  logic        a_en_i,
  output amo_dec_t    dec_o
);

  logic [6:0] opcode;
  logic [2:0] width_f;
  logic [4:0] sel_f;
  logic       opc_ok;
  logic       width_ok;
  logic       sel_ok;
  amo_op_e    op_d;

  assign opcode  = insn_i[6:0];
  assign width_f = insn_i[14:12];
  assign sel_f   = insn_i[31:27];

  assign opc_ok = (opcode == OPC_ATOMIC);

  generate
    if (DWORD_EN) begin : g_dword
      assign width_ok = (width_f == WIDTH_WORD) || (width_f == WIDTH_DWORD);
    end else begin : g_word_only
      assign width_ok = (width_f == WIDTH_WORD);
    end
  endgenerate

  always_comb begin
    sel_ok = 1'b1;
    op_d   = OP_ADD;
    unique case (sel_f)
      SEL_ADD:  op_d = OP_ADD;
      SEL_AND:  op_d = OP_AND;
      SEL_MAX:  op_d = OP_MAX;
      SEL_MAXU: op_d = OP_MAXU;
      default:  sel_ok = 1'b0;
    endcase
  end

  always_comb begin
    dec_o.legal = a_en_i && opc_ok && width_ok && sel_ok;
    dec_o.op    = op_d;
    dec_o.dword = (width_f == WIDTH_DWORD);
    dec_o.aq    = insn_i[26];
    dec_o.rl    = insn_i[25];
    dec_o.rd    = insn_i[11:7];
  end

endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
(
  input  amo_op_e              op_i,
  input  logic                 dword_i,
  input  logic                 lane_hi_i,
  input  logic [XLEN-1:0]      old_i,
  input  logic [XLEN-1:0]      opnd_i,
  output logic [XLEN-1:0]      wdata_o,
  output logic [NBYTES-1:0]    be_o,
  output logic [XLEN-1:0]      rd_o
);

  logic [31:0] old_word;
  logic [31:0] res_word;
  logic [63:0] res_dword;

  assign old_word  = lane_hi_i ? old_i[63:32] : old_i[31:0];
  assign res_word  = combine32(op_i, old_word, opnd_i[31:0]);
  assign res_dword = combine64(op_i, old_i, opnd_i);

  always_comb begin
    if (dword_i) begin
      wdata_o = res_dword;
      be_o    = 8'hFF;
      rd_o    = old_i;
    end else begin
      wdata_o = {res_word, res_word};
      be_o    = lane_hi_i ? 8'hF0 : 8'h0F;
      rd_o    = sext32(old_word);
    end
  end

endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  amo_dec_t         dec_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [XLEN-1:0]  rs2_i,
  input  logic             mem_rsp_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic [XLEN-1:0]  rd_calc_i,
  output amo_dec_t         dec_q_o,
  output logic [XLEN-1:0]  addr_q_o,
  output logic [XLEN-1:0]  rs2_q_o,
  output logic [XLEN-1:0]  old_q_o,
  output logic             ready_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic [XLEN-1:0]  rd_val_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic             mem_lock_o
);

  amo_state_e state_q;
  amo_dec_t   dec_q;
  logic [XLEN-1:0] addr_q, rs2_q, old_q, rd_q;
  logic ill_q;

  // named internal events
  logic accept_ev;
  logic accept_bad_ev;
  logic read_done_ev;
  logic write_done_ev;

  assign accept_ev     = (state_q == ST_IDLE) && start_i;
  assign accept_bad_ev = accept_ev && !dec_i.legal;
  assign read_done_ev  = (state_q == ST_READ) && mem_rsp_i;
  assign write_done_ev = (state_q == ST_WRITE) && mem_rsp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dec_q   <= '0;
      addr_q  <= '0;
      rs2_q   <= '0;
      old_q   <= '0;
      rd_q    <= '0;
      ill_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_ev) begin
          dec_q  <= dec_i;
          addr_q <= rs1_i;
          rs2_q  <= rs2_i;
          rd_q   <= '0;
          ill_q  <= !dec_i.legal;
          state_q <= dec_i.legal ? ST_READ : ST_DONE;
        end
        ST_READ: if (read_done_ev) begin
          old_q   <= mem_rdata_i;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (write_done_ev) begin
          rd_q    <= rd_calc_i;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = (state_q == ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign illegal_o  = done_o && ill_q;
  assign rd_val_o   = done_o ? rd_q : '0;
  assign mem_req_o  = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o   = (state_q == ST_WRITE);
  assign mem_lock_o = mem_req_o;
  assign dec_q_o    = dec_q;
  assign addr_q_o   = addr_q;
  assign rs2_q_o    = rs2_q;
  assign old_q_o    = old_q;

  // R9 / R10: a rejected instruction goes straight to completion
  assert_no_access_on_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad_ev |=> (!mem_req_o && done_o && illegal_o));

  // R2: read response leads directly into the write phase
  assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    read_done_ev |=> (mem_req_o && mem_we_o));

  // R12: single-cycle completion pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12: never ready while a request is outstanding
  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !ready_o);

endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
  import amo_pkg::*;
#(
  parameter bit DWORD_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] insn_i,
  input  logic [63:0] rs1_val_i,
  input  logic [63:0] rs2_val_i,
  input  logic        a_en_i,
  output logic        ready_o,
  output logic        done_o,
  output logic        illegal_o,
  output logic [4:0]  rd_idx_o,
  output logic [63:0] rd_val_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic        mem_lock_o,
  output logic        mem_aq_o,
  output logic        mem_rl_o,
  output logic [63:0] mem_addr_o,
  output logic [7:0]  mem_be_o,
  output logic [63:0] mem_wdata_o,
  input  logic        mem_rsp_i,
  input  logic [63:0] mem_rdata_i
);

  amo_dec_t dec_now, dec_q;
  logic [XLEN-1:0] addr_q, rs2_q, old_q, rd_calc, wdata_c;
  logic [NBYTES-1:0] be_c;

  amo_decode #(.DWORD_EN(DWORD_EN)) u_decode (
    .insn_i (insn_i),
    .a_en_i (a_en_i),
    .dec_o  (dec_now)
  );

  amo_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dec_i       (dec_now),
    .rs1_i       (rs1_val_i),
    .rs2_i       (rs2_val_i),
    .mem_rsp_i   (mem_rsp_i),
    .mem_rdata_i (mem_rdata_i),
    .rd_calc_i   (rd_calc),
    .dec_q_o     (dec_q),
    .addr_q_o    (addr_q),
    .rs2_q_o     (rs2_q),
    .old_q_o     (old_q),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .rd_val_o    (rd_val_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_lock_o  (mem_lock_o)
  );

  amo_datapath u_datapath (
    .op_i      (dec_q.op),
    .dword_i   (dec_q.dword),
    .lane_hi_i (addr_q[2]),
    .old_i     (old_q),
    .opnd_i    (rs2_q),
    .wdata_o   (wdata_c),
    .be_o      (be_c),
    .rd_o      (rd_calc)
  );

  assign mem_addr_o  = addr_q;
  assign mem_be_o    = mem_req_o ? be_c : '0;
  assign mem_wdata_o = mem_we_o ? wdata_c : '0;
  assign mem_aq_o    = mem_req_o && dec_q.aq;
  assign mem_rl_o    = mem_req_o && dec_q.rl;
  assign rd_idx_o    = done_o ? dec_q.rd : '0;

  // R2: lock covers every request
  assert_lock_on_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_lock_o);

  // R2: write phase reuses the read address
  assert_same_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && !$past(mem_we_o)) |-> ($past(mem_req_o) && mem_addr_o == $past(mem_addr_o)));

  // R7: word access enables exactly four bytes in one half
  assert_word_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !dec_q.dword) |-> ($countones(mem_be_o) == 4 && (mem_be_o == 8'h0F || mem_be_o == 8'hF0)));

  // R8: doubleword access enables all bytes
  assert_dword_be_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && dec_q.dword) |-> (mem_be_o == 8'hFF));

  // R2: write data steady while the write is held
  assert_wdata_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> $stable(mem_wdata_o));

endmodule

// File: tb/amo_rmw_unit_tb.sv
module amo_rmw_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] rs1_val_i = '0;
  logic [63:0] rs2_val_i = '0;
  logic        a_en_i = 1'b1;
  logic        ready_o, done_o, illegal_o;
  logic [4:0]  rd_idx_o;
  logic [63:0] rd_val_o;
  logic        mem_req_o, mem_we_o, mem_lock_o, mem_aq_o, mem_rl_o;
  logic [63:0] mem_addr_o, mem_wdata_o;
  logic [7:0]  mem_be_o;
  logic        mem_rsp_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;

  always #5 clk = ~clk;

  amo_rmw_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
    .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .a_en_i(a_en_i),
    .ready_o(ready_o), .done_o(done_o), .illegal_o(illegal_o),
    .rd_idx_o(rd_idx_o), .rd_val_o(rd_val_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_lock_o(mem_lock_o),
    .mem_aq_o(mem_aq_o), .mem_rl_o(mem_rl_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .mem_rsp_i(mem_rsp_i), .mem_rdata_i(mem_rdata_i)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: one 64-bit word, one-cycle response
  logic [63:0] mem64 = '0;
  always @(posedge clk) begin
    mem_rsp_i <= 1'b0;
    if (mem_req_o && !mem_rsp_i) begin
      mem_rsp_i <= 1'b1;
      if (mem_we_o) begin
        for (int b = 0; b < 8; b++)
          if (mem_be_o[b]) mem64[b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
      end else begin
        mem_rdata_i <= mem64;
      end
    end
  end

  // port monitor
  int n_rd = 0, n_wr = 0, n_req_cyc = 0, lock_bad = 0, order_bad = 0;
  logic [63:0] rd_addr_seen, wr_addr_seen;
  logic [7:0]  wr_be_seen;
  logic        aq_seen, rl_seen, hint_bad;
  always @(negedge clk) begin
    if (mem_req_o) begin
      n_req_cyc++;
      if (!mem_lock_o) lock_bad++;
      if (mem_aq_o !== aq_seen || mem_rl_o !== rl_seen) hint_bad = 1'b1;
      if (mem_rsp_i) begin
        if (mem_we_o) begin
          n_wr++;
          wr_addr_seen = mem_addr_o;
          wr_be_seen = mem_be_o;
          if (n_rd == 0) order_bad++;
        end else begin
          n_rd++;
          rd_addr_seen = mem_addr_o;
        end
      end
    end
  end

  int done_pulses = 0;
  always @(negedge clk) if (done_o) done_pulses++;

  function automatic logic [31:0] mk_insn(logic [4:0] sel, logic aq, logic rl,
                                          logic [2:0] wid, logic [4:0] rd, logic [6:0] opc);
    return {sel, aq, rl, 5'd12, 5'd11, wid, rd, opc};
  endfunction

  int timeouts = 0;
  task automatic run_insn(logic [31:0] insn, logic [63:0] a, logic [63:0] b, logic en);
    int waited;
    n_rd = 0; n_wr = 0; n_req_cyc = 0; lock_bad = 0; order_bad = 0;
    hint_bad = 1'b0; aq_seen = insn[26]; rl_seen = insn[25];
    @(negedge clk);
    insn_i = insn; rs1_val_i = a; rs2_val_i = b; a_en_i = en; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (!done_o && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    if (!done_o) timeouts++;
  endtask

  // stimulus table: sel, dword, aq, rl, hi-lane, mem init, rs2, exp rd, exp mem
  localparam int NV = 12;
  localparam logic [264:0] VEC [NV] = '{
    {5'b00000, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0008},
    {5'b00000, 1'b1, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
    {5'b00000, 1'b0, 1'b1, 1'b1, 1'b0, 64'hAAAA_AAAA_7FFF_FFFF, 64'h1234_5678_0000_0001, 64'h0000_0000_7FFF_FFFF, 64'hAAAA_AAAA_8000_0000},
    {5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 64'h8000_0000_1111_1111, 64'h0000_0000_0000_0010, 64'hFFFF_FFFF_8000_0000, 64'h8000_0010_1111_1111},
    {5'b01100, 1'b1, 1'b0, 1'b0, 1'b0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF0F0_F0F0_F0F0_F0F0, 64'hF000_F000_F000_F000},
    {5'b01100, 1'b0, 1'b0, 1'b0, 1'b0, 64'h1234_5678_FFFF_0000, 64'hFFFF_FFFF_0F0F_0F0F, 64'hFFFF_FFFF_FFFF_0000, 64'h1234_5678_0F0F_0000},
    {5'b10100, 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0001},
    {5'b11100, 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE},
    {5'b10100, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_7FFF_FFFF},
    {5'b11100, 1'b0, 1'b0, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_8000_0000, 64'h8000_0000_0000_0000},
    {5'b11100, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0003, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005},
    {5'b10100, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0007}
  };

  function automatic string op_tag(logic [4:0] sel);
    case (sel)
      5'b00000: return "R3 add";
      5'b01100: return "R4 and";
      5'b10100: return "R5 max";
      default:  return "R6 maxu";
    endcase
  endfunction

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", wd);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R13: reset state
    repeat (3) @(negedge clk);
    chk("R13 ready after reset", ready_o, 1);
    chk("R13 no request after reset", {mem_req_o, mem_lock_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 idle after release", {ready_o, mem_req_o, done_o}, 3'b100);

    for (int i = 0; i < NV; i++) begin
      logic [4:0]  sel;
      logic        dw, aq, rl, hi;
      logic [63:0] m0, b, erd, emem, addr;
      string t;
      {sel, dw, aq, rl, hi, m0, b, erd, emem} = VEC[i];
      t = op_tag(sel);
      addr = 64'h0000_0000_0000_1000 | {61'd0, hi, 2'b00};
      mem64 = m0;
      run_insn(mk_insn(sel, aq, rl, dw ? 3'b011 : 3'b010, 5'd9, 7'b0101111), addr, b, 1'b1);
      chk({t, " rd value (R7 sign-extend on word)"}, rd_val_o, erd);
      chk("R1 rd index", rd_idx_o, 5'd9);
      chk("R1 legal", illegal_o, 0);
      @(negedge clk);
      chk("R12 done one cycle", done_o, 0);
      chk({t, " stored value (R7/R8 lanes)"}, mem64, emem);
      chk("R2 one read one write in order", {n_rd[3:0], n_wr[3:0], order_bad[3:0], lock_bad[3:0]}, 16'h1100);
      chk("R2 same address", {rd_addr_seen == addr, wr_addr_seen == addr}, 2'b11);
      chk(dw ? "R8 byte enables" : "R7 byte enables", wr_be_seen, dw ? 8'hFF : (hi ? 8'hF0 : 8'h0F));
      chk("R11 aq/rl forwarded", hint_bad, 0);
    end

    // R9: extension disabled
    mem64 = 64'h55;
    run_insn(mk_insn(5'b00000, 1'b0, 1'b0, 3'b011, 5'd4, 7'b0101111), 64'h1000, 64'h1, 1'b0);
    chk("R9 illegal when disabled", illegal_o, 1);
    chk("R9 rd zero", rd_val_o, 0);
    @(negedge clk);
    chk("R9 no memory access", n_req_cyc, 0);
    chk("R9 memory untouched", mem64, 64'h55);

    // R10: unsupported operation, width and opcode
    run_insn(mk_insn(5'b00001, 1'b0, 1'b0, 3'b011, 5'd4, 7'b0101111), 64'h1000, 64'h1, 1'b1);
    chk("R10 bad operation illegal", illegal_o, 1);
    @(negedge clk);
    chk("R10 bad operation no access", n_req_cyc, 0);
    run_insn(mk_insn(5'b00000, 1'b0, 1'b0, 3'b000, 5'd4, 7'b0101111), 64'h1000, 64'h1, 1'b1);
    chk("R10 bad width illegal", illegal_o, 1);
    @(negedge clk);
    chk("R10 bad width no access", n_req_cyc, 0);
    run_insn(mk_insn(5'b00000, 1'b0, 1'b0, 3'b010, 5'd4, 7'b0110011), 64'h1000, 64'h1, 1'b1);
    chk("R10 bad opcode illegal", illegal_o, 1);
    @(negedge clk);
    chk("R10 bad opcode no access", n_req_cyc, 0);
    chk("R10 memory untouched", mem64, 64'h55);

    // R12: start while busy is ignored
    mem64 = 64'd10;
    done_pulses = 0;
    @(negedge clk);
    insn_i = mk_insn(5'b00000, 1'b0, 1'b0, 3'b011, 5'd3, 7'b0101111);
    rs1_val_i = 64'h1000; rs2_val_i = 64'd1; a_en_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R12 not ready when busy", ready_o, 0);
    rs2_val_i = 64'd100; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    chk("R12 single completion", done_pulses, 1);
    chk("R12 second start ignored", mem64, 64'd11);
    chk("R12 ready again", ready_o, 1);

    if (timeouts != 0) chk("R12 completion timeout", timeouts, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule